// File: doc/BRIEF.md
# Cascadable Column Data Sampler

This block is the digital front end of one column driver that can be chained with others of its kind. A shared sampling clock carries three 6-bit grayscale words per rising edge, one each for channels A, B and C. The block sits idle until its upstream neighbour raises the enable link. It then writes one column position per clock edge until every position is filled. After the last write it pulses the enable link toward the next driver in the chain and goes back to idle. A direction input sets the fill order. The same input also decides which of the two link pins listens and which one talks, so one design can be chained either way.

Behind the sampling register sits a held register. A load strobe copies the whole sampling register into it. The held contents are presented as one flat output word, together with a valid flag that is high only while the load strobe is high. The valid flag stands in for the high-impedance state of the analog outputs. The converters and the analog drive are outside this block.

Top module: `colsamp_top`

## Requirements
- R1: When `dir_up` is 1, `link_a_i` is the enable input and `link_b_o` is the enable output. When `dir_up` is 0, `link_b_i` is the input and `link_a_o` is the output. The output that is not selected stays 0.
- R2: A high on the selected enable input is taken only while the block is idle. An enable that arrives during a fill neither restarts the fill nor changes the data that is written.
- R3: The first write happens on the edge that follows the edge that took the enable. Each later edge writes one position. Position p (0-based) occupies `col_data[p*18 +: 18]`, with word A in bits 5:0, B in bits 11:6 and C in bits 17:12. Each word is unsigned, with bit 5 weighing 32 and bit 0 weighing 1.
- R4: With the direction held at 1, positions are written from 0 up to NPOS-1. With it held at 0, they are written from NPOS-1 down to 0.
- R5: The selected enable output is high for exactly the one cycle that follows the edge writing the last position, and is low at all other times. The block is then idle and accepts a new enable.
- R6: On an edge where `load` is 1, the held register takes the sampling register contents as they stood before that edge. On any other edge the held register keeps its value.
- R7: `col_valid` equals `load`. It is 0 whenever `load` is 0.
- R8: A synchronous reset makes the block idle, clears the position counter and both registers, and forces both enable outputs to 0.
- R9: The direction is captured when the enable is taken. Changes on `dir_up` during a fill affect neither the fill order nor which pin carries the enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_up | input | 1 | Fill direction and link role select |
| link_a_i | input | 1 | Enable input, used when dir_up=1 |
| link_b_i | input | 1 | Enable input, used when dir_up=0 |
| link_a_o | output | 1 | Enable output, used when fill direction is 0 |
| link_b_o | output | 1 | Enable output, used when fill direction is 1 |
| word_a | input | DW | Channel A grayscale word |
| word_b | input | DW | Channel B grayscale word |
| word_c | input | DW | Channel C grayscale word |
| load | input | 1 | Copy strobe into the held register |
| col_data | output | NPOS*3*DW | Held register contents, flattened |
| col_valid | output | 1 | Outputs valid (high only while load is high) |

## Verification
The bench builds the block with NPOS=5 and keeps DW=6. With only five positions, every position in both fill orders is written, loaded and compared within a few dozen cycles, and each pass uses new word values. The small depth also brings both end positions and the hand-off pulse into many passes. This leaves room for fills with stray enables and a mid-fill direction flip, a reset in the middle of a fill, and a load that lands between two writes.

// File: rtl/colsamp_pkg.sv
package colsamp_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_FILL = 1'b1
    } seq_state_e;

    localparam int unsigned NCH = 3;
endpackage

// File: rtl/colsamp_seq.sv
module colsamp_seq
    import colsamp_pkg::*;
#(
    parameter int unsigned NPOS = 80,
    localparam int unsigned IW = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_up,
    input  logic          link_a_i,
    input  logic          link_b_i,
    output logic          link_a_o,
    output logic          link_b_o,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx
);
    localparam logic [IW-1:0] LAST = IW'(NPOS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [IW-1:0] pos;
        logic          dir;
        logic          pulse;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: SEQ_IDLE, pos: '0, dir: 1'b1, pulse: 1'b0};

    seq_t s_d, s_q;
    logic en_in;
    logic at_end;

    always_comb begin
        s_d    = s_q;
        s_d.pulse = 1'b0;
        en_in  = dir_up ? link_a_i : link_b_i;
        at_end = s_q.dir ? (s_q.pos == LAST) : (s_q.pos == '0);
        case (s_q.state)
            SEQ_IDLE: begin
                if (en_in) begin
                    s_d.state = SEQ_FILL;
                    s_d.dir   = dir_up;
                    s_d.pos   = dir_up ? '0 : LAST;
                end
            end
            SEQ_FILL: begin
                if (at_end) begin
                    s_d.state = SEQ_IDLE;
                    s_d.pulse = 1'b1;
                end else if (s_q.dir) begin
                    s_d.pos = s_q.pos + 1'b1;
                end else begin
                    s_d.pos = s_q.pos - 1'b1;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= SEQ_RST;
        else     s_q <= s_d;
    end

    assign wr_en    = (s_q.state == SEQ_FILL);
    assign wr_idx   = s_q.pos;
    assign link_b_o = s_q.pulse & s_q.dir;
    assign link_a_o = s_q.pulse & ~s_q.dir;

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        (link_a_o | link_b_o) |=> !(link_a_o | link_b_o))
        else $error("enable output longer than one cycle");

    p_idle_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == SEQ_IDLE && (dir_up ? link_a_i : link_b_i)) |=> wr_en)
        else $error("enable not taken while idle");

    p_dir_held_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !at_end) |=> (wr_en && $stable(s_q.dir)))
        else $error("direction changed during fill");

    p_pos_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx <= LAST))
        else $error("position out of range");

    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (!wr_en && !link_a_o && !link_b_o))
        else $error("reset did not return to idle");
endmodule

// File: rtl/colsamp_sreg.sv
module colsamp_sreg #(
    parameter int unsigned NPOS = 80,
    parameter int unsigned SLOT = 18,
    localparam int unsigned IW = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [SLOT-1:0]      slot_in,
    output logic [NPOS*SLOT-1:0] flat_out
);
    logic [SLOT-1:0] mem_d [NPOS];
    logic [SLOT-1:0] mem_q [NPOS];

    always_comb begin
        for (int i = 0; i < NPOS; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_idx == IW'(i))) mem_d[i] = slot_in;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPOS; i++) begin
            if (rst) mem_q[i] <= '0;
            else     mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < NPOS; g++) begin : g_flat
        assign flat_out[g*SLOT +: SLOT] = mem_q[g];
    end

    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat_out))
        else $error("sampling register changed without a write");
endmodule

// File: rtl/colsamp_hold.sv
module colsamp_hold #(
    parameter int unsigned W = 1440
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] src,
    output logic [W-1:0] held,
    output logic         valid
);
    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = load ? src : hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign held  = hold_q;
    assign valid = load;

    p_hold_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held))
        else $error("held register changed without load");

    p_hold_copy_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (held == $past(src)))
        else $error("held register did not copy");
endmodule

// File: rtl/colsamp_top.sv
module colsamp_top
    import colsamp_pkg::*;
#(
    parameter int unsigned NPOS = 80,
    parameter int unsigned DW   = 6,
    localparam int unsigned SLOT = NCH * DW,
    localparam int unsigned W    = NPOS * SLOT,
    localparam int unsigned IW   = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_up,
    input  logic          link_a_i,
    input  logic          link_b_i,
    output logic          link_a_o,
    output logic          link_b_o,
    input  logic [DW-1:0] word_a,
    input  logic [DW-1:0] word_b,
    input  logic [DW-1:0] word_c,
    input  logic          load,
    output logic [W-1:0]  col_data,
    output logic          col_valid
);
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [W-1:0]  samp_flat;

    colsamp_seq #(.NPOS(NPOS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .dir_up  (dir_up),
        .link_a_i(link_a_i),
        .link_b_i(link_b_i),
        .link_a_o(link_a_o),
        .link_b_o(link_b_o),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx)
    );

    colsamp_sreg #(.NPOS(NPOS), .SLOT(SLOT)) u_sreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .slot_in ({word_c, word_b, word_a}),
        .flat_out(samp_flat)
    );

    colsamp_hold #(.W(W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .src  (samp_flat),
        .held (col_data),
        .valid(col_valid)
    );

    p_links_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(link_a_o && link_b_o))
        else $error("both enable outputs high");

    p_valid_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !load |-> !col_valid)
        else $error("valid without load");
endmodule

// File: tb/colsamp_top_bench.sv
module colsamp_top_bench;
    localparam int unsigned NPOS = 5;
    localparam int unsigned DW   = 6;
    localparam int unsigned SLOT = 3 * DW;
    localparam int unsigned W    = NPOS * SLOT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_up = 1'b1;
    logic link_a_i = 1'b0, link_b_i = 1'b0;
    logic link_a_o, link_b_o;
    logic [DW-1:0] word_a = '0, word_b = '0, word_c = '0;
    logic load = 1'b0;
    logic [W-1:0] col_data;
    logic col_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [SLOT-1:0] exp_mem [NPOS];
    logic [W-1:0]    exp_held = '0;

    always #2.5 clk = ~clk;

    colsamp_top #(.NPOS(NPOS), .DW(DW)) u_colsamp_top (
        .clk(clk), .rst(rst), .dir_up(dir_up),
        .link_a_i(link_a_i), .link_b_i(link_b_i),
        .link_a_o(link_a_o), .link_b_o(link_b_o),
        .word_a(word_a), .word_b(word_b), .word_c(word_c),
        .load(load), .col_data(col_data), .col_valid(col_valid)
    );

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] pack_exp();
        logic [W-1:0] v;
        for (int i = 0; i < NPOS; i++) v[i*SLOT +: SLOT] = exp_mem[i];
        return v;
    endfunction

    function automatic logic [SLOT-1:0] slot_val(input int pass, input int idx);
        int a, b, c;
        a = (pass * 11 + idx * 5 + 1) % 64;
        b = (pass * 13 + idx * 3 + 40) % 64;
        c = (pass * 7 + idx * 9 + 17) % 64;
        return {6'(c), 6'(b), 6'(a)};
    endfunction

    task automatic do_load();
        @(negedge clk);
        load = 1'b1;
        exp_held = pack_exp();
        #1 chk_bit("R7 valid with load", col_valid, 1'b1);
        @(negedge clk);
        chk_vec("R6 copy on load", col_data, exp_held);
        load = 1'b0;
        #1 chk_bit("R7 invalid without load", col_valid, 1'b0);
        @(negedge clk);
        chk_vec("R6 held stable", col_data, exp_held);
    endtask

    // One complete fill; stray=1 keeps the enable inputs high mid-fill (R2),
    // flip=1 toggles dir_up mid-fill (R9).
    task automatic run_fill(input int pass, input logic dir, input bit stray, input bit flip);
        @(negedge clk);
        dir_up = dir;
        if (dir) link_a_i = 1'b1; else link_b_i = 1'b1;
        for (int k = 0; k < NPOS; k++) begin
            @(negedge clk);
            chk_bit("R5 no pulse during fill", link_a_o | link_b_o, 1'b0);
            link_a_i = stray && (k < NPOS - 1);
            link_b_i = stray && (k < NPOS - 1);
            if (flip && k == 1) dir_up = ~dir;
            begin
                int idx;
                idx = dir ? k : NPOS - 1 - k;
                {word_c, word_b, word_a} = slot_val(pass, idx);
                exp_mem[idx] = slot_val(pass, idx);
            end
        end
        @(negedge clk);
        dir_up = dir;
        chk_bit("R1 R5 active enable output", dir ? link_b_o : link_a_o, 1'b1);
        chk_bit("R1 inactive enable output", dir ? link_a_o : link_b_o, 1'b0);
        {word_c, word_b, word_a} = '1;
        @(negedge clk);
        chk_bit("R5 pulse one cycle", link_a_o | link_b_o, 1'b0);
        chk_vec("R2 R9 hold before load", col_data, exp_held);
        do_load();
        chk_vec("R3 R4 fill contents", col_data, pack_exp());
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: got %0d expected below 20000 cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        for (int i = 0; i < NPOS; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_vec("R8 reset held data", col_data, '0);
        chk_bit("R8 reset link a", link_a_o, 1'b0);
        chk_bit("R8 reset link b", link_b_o, 1'b0);
        chk_bit("R7 reset valid", col_valid, 1'b0);

        run_fill(0, 1'b1, 1'b0, 1'b0);
        run_fill(1, 1'b0, 1'b0, 1'b0);
        run_fill(2, 1'b1, 1'b1, 1'b1);
        run_fill(3, 1'b0, 1'b1, 1'b1);
        for (int p = 4; p < 10; p++) run_fill(p, p[0] ? 1'b0 : 1'b1, 1'b0, 1'b0);

        // R1: the unselected input does not start a fill
        @(negedge clk);
        dir_up = 1'b1;
        link_b_i = 1'b1;
        {word_c, word_b, word_a} = '1;
        repeat (NPOS + 2) @(negedge clk);
        link_b_i = 1'b0;
        chk_bit("R1 wrong input ignored", link_a_o | link_b_o, 1'b0);
        do_load();
        chk_vec("R1 no fill from wrong input", col_data, pack_exp());

        // R6: load between writes copies pre-edge contents
        @(negedge clk);
        dir_up = 1'b1;
        link_a_i = 1'b1;
        @(negedge clk);
        link_a_i = 1'b0;
        {word_c, word_b, word_a} = slot_val(20, 0);
        @(negedge clk);
        exp_mem[0] = slot_val(20, 0);
        {word_c, word_b, word_a} = slot_val(20, 1);
        load = 1'b1;
        exp_held = pack_exp();
        @(negedge clk);
        load = 1'b0;
        exp_mem[1] = slot_val(20, 1);
        chk_vec("R6 load mid fill", col_data, exp_held);

        // R8: reset mid-fill clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NPOS; i++) exp_mem[i] = '0;
        exp_held = '0;
        chk_vec("R8 reset clears held", col_data, '0);
        repeat (NPOS + 1) begin
            @(negedge clk);
            chk_bit("R8 no pulse after reset", link_a_o | link_b_o, 1'b0);
        end
        do_load();
        chk_vec("R8 sampling cleared", col_data, '0);
        run_fill(30, 1'b1, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule